// File: doc/BRIEF.md
# Translation Table Update Sequencer

This block carries out update and query commands against an I/O translation table. The table itself is held outside the block. The sequencer reaches it through a write port and through a read port with one cycle of latency. A command names an I/O bus address. The sequencer aligns that address down to a page boundary, subtracts a programmable bus offset, and turns the result into a table index. It checks the index against the current entry count, then writes or reads the entry.

Four operations are supported. A single put writes one entry. A fill writes one value across a run of consecutive pages. A list copy fetches entries from a list in system memory through a read-request/read-data master port and writes them to consecutive pages. A get returns one stored entry. Each written entry produces an invalidation notice on the following cycle, so that downstream translation caches can drop stale state. Every command ends with a one-cycle done pulse that carries a success or parameter-error status. If a multi-page command hits a page outside the table, it stops at that page and leaves the entries it has already written in place.

Top module: `tts_seq`

## Requirements
- R1: A command address is first cleared of its low PAGE_SHIFT bits. The table index is then (address − bus_offset_i) >> PAGE_SHIFT, using IOBA_W-bit wrap-around arithmetic, and a put (cmd_op_i = 0) writes cmd_data_i at that index.
- R2: An index at or above num_entries_i produces a parameter error and no write for that page. A multi-page command stops at the first such page, and every entry it wrote before that page keeps its new value.
- R3: A fill (cmd_op_i = 1) writes cmd_data_i to cmd_count_i consecutive pages, advancing by one page per entry. If the count exceeds num_entries_i the fill reports an error and writes nothing. A count of zero reports success and writes nothing.
- R4: A list copy (cmd_op_i = 2) fails at once, with no memory read and no write, when the count is above 512, when the count is zero, or when any of bits [11:0] of the list address (cmd_data_i[MADDR_W-1:0]) is set.
- R5: Entry i of a list copy is read from list address + 8·i. The returned word carries the lowest-addressed byte in bits [7:0], and that byte becomes the most significant byte of the stored entry. A page's memory read is issued only after that page's index has passed the range check.
- R6: The cycle after each table write, a notice is raised. It carries the page-aligned rebased address, the entry with its low PAGE_SHIFT bits cleared, the offset mask 2^PAGE_SHIFT − 1, and a permission taken from entry bits [1:0] (0 none, 1 read, 2 write, 3 read/write).
- R7: A get (cmd_op_i = 3) returns the stored entry at the computed index on rd_data_o with success status. An out-of-range index gives a parameter error.
- R8: done_o pulses for one cycle. status_o is 0 for success and 1 for parameter error. On a successful command with writes, done_o comes exactly one cycle after the last write.
- R9: busy_o is high from the cycle after a command is accepted through its done cycle, and low otherwise. A cmd_valid_i seen while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_op_i | input | 2 | 0 put, 1 fill, 2 list copy, 3 get |
| cmd_ioba_i | input | IOBA_W | I/O bus address of the first page |
| cmd_data_i | input | ENTRY_W | Entry value (put/fill) or list address (list copy) |
| cmd_count_i | input | CNT_W | Page count for fill and list copy |
| busy_o | output | 1 | Command in progress |
| bus_offset_i | input | IOBA_W | Bus address of table index 0 |
| num_entries_i | input | IDX_W+1 | Number of valid table entries |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_re_o | output | 1 | Table read strobe, data one cycle later |
| tbl_idx_o | output | IDX_W | Table index |
| tbl_wdata_o | output | ENTRY_W | Table write data |
| tbl_rdata_i | input | ENTRY_W | Table read data |
| mem_req_o | output | 1 | List read request, one cycle |
| mem_addr_o | output | MADDR_W | List read byte address |
| mem_rvalid_i | input | 1 | List read data valid |
| mem_rdata_i | input | ENTRY_W | List read data, lowest address in bits [7:0] |
| inv_valid_o | output | 1 | Invalidation notice strobe |
| inv_iova_o | output | IOBA_W | Page-aligned rebased I/O address |
| inv_pa_o | output | ENTRY_W | Page-aligned translated address |
| inv_mask_o | output | ENTRY_W | In-page offset mask |
| inv_perm_o | output | 2 | Access permission of the new entry |
| done_o | output | 1 | Command complete pulse |
| status_o | output | 1 | 0 success, 1 parameter error, valid with done_o |
| rd_data_o | output | ENTRY_W | Entry returned by the last successful get |

## Verification
The hardest case to reach from the ports is a partial multi-page command. The run has to start inside the table and cross its upper bound, so that some pages are written and the rest are refused. The stimulus places fills and list copies a few pages below num_entries_i with counts that run past the end. Afterwards it reads back the last in-range entry with a get, which shows that the earlier writes survived the error and that no memory read was issued for the refused page. A second hard case is a command strobe that arrives during a long fill. The stimulus drives one mid-run, and the write-by-write comparison shows that no extra write occurred.

// File: rtl/tts_pkg.sv
package tts_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_FILL = 2'd1,
    OP_LIST = 2'd2,
    OP_GET  = 2'd3
  } tts_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_STEP,
    S_FETCH,
    S_WAIT,
    S_RD,
    S_RD_WAIT,
    S_DONE
  } tts_state_e;

  localparam logic ST_OK    = 1'b0;
  localparam logic ST_PARAM = 1'b1;

endpackage

// File: rtl/tts_index_calc.sv
module tts_index_calc #(
  parameter int IOBA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W     = IOBA_W - PAGE_SHIFT
) (
  input  logic [IOBA_W-1:0] addr_i,
  input  logic [IOBA_W-1:0] base_i,
  input  logic [IDX_W:0]    count_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              in_range_o,
  output logic [IOBA_W-1:0] iova_o
);
  localparam logic [IOBA_W-1:0] PG_MASK = ~((IOBA_W'(1) << PAGE_SHIFT) - IOBA_W'(1));

  logic [IOBA_W-1:0] rebased;

  assign rebased    = addr_i - base_i;
  assign idx_o      = rebased[IOBA_W-1:PAGE_SHIFT];
  assign in_range_o = {1'b0, idx_o} < count_i;
  assign iova_o     = rebased & PG_MASK;
endmodule

// File: rtl/tts_list_fetch.sv
module tts_list_fetch #(
  parameter int ENTRY_W = 64,
  parameter int MADDR_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MADDR_W-1:0] addr_i,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               entry_valid_o,
  output logic [ENTRY_W-1:0] entry_o
);
  localparam int NB = ENTRY_W / 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      mem_req_o <= start_i;
      if (start_i) mem_addr_o <= addr_i;
    end
  end

  // list words are big-endian: lowest-address byte becomes the MSB
  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign entry_o[8*b +: 8] = mem_rdata_i[8*(NB-1-b) +: 8];
  end

  assign entry_valid_o = mem_rvalid_i;

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R5
  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0)); // R5
endmodule

// File: rtl/tts_notice.sv
module tts_notice #(
  parameter int IOBA_W     = 32,
  parameter int ENTRY_W    = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IOBA_W-1:0]  iova_i,
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               inv_valid_o,
  output logic [IOBA_W-1:0]  inv_iova_o,
  output logic [ENTRY_W-1:0] inv_pa_o,
  output logic [ENTRY_W-1:0] inv_mask_o,
  output logic [1:0]         inv_perm_o
);
  localparam logic [ENTRY_W-1:0] OFS_MASK = (ENTRY_W'(1) << PAGE_SHIFT) - ENTRY_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_valid_o <= 1'b0;
      inv_iova_o  <= '0;
      inv_pa_o    <= '0;
      inv_perm_o  <= 2'd0;
    end else begin
      inv_valid_o <= we_i;
      if (we_i) begin
        inv_iova_o <= iova_i;
        inv_pa_o   <= entry_i & ~OFS_MASK;
        inv_perm_o <= entry_i[1:0];
      end
    end
  end

  assign inv_mask_o = OFS_MASK;

  AST_NOTICE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> inv_valid_o); // R6
  AST_NOTICE_HAS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> $past(we_i)); // R6
endmodule

// File: rtl/tts_seq.sv
module tts_seq
  import tts_pkg::*;
#(
  parameter int IOBA_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_W     = 64,
  parameter int MADDR_W     = 40,
  parameter int CNT_W       = 16,
  parameter int LIST_MAX    = 512,
  parameter int LIST_ALIGN  = 12,
  localparam int IDX_W      = IOBA_W - PAGE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [IOBA_W-1:0]  cmd_ioba_i,
  input  logic [ENTRY_W-1:0] cmd_data_i,
  input  logic [CNT_W-1:0]   cmd_count_i,
  output logic               busy_o,
  input  logic [IOBA_W-1:0]  bus_offset_i,
  input  logic [IDX_W:0]     num_entries_i,
  output logic               tbl_we_o,
  output logic               tbl_re_o,
  output logic [IDX_W-1:0]   tbl_idx_o,
  output logic [ENTRY_W-1:0] tbl_wdata_o,
  input  logic [ENTRY_W-1:0] tbl_rdata_i,
  output logic               mem_req_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i,
  output logic               inv_valid_o,
  output logic [IOBA_W-1:0]  inv_iova_o,
  output logic [ENTRY_W-1:0] inv_pa_o,
  output logic [ENTRY_W-1:0] inv_mask_o,
  output logic [1:0]         inv_perm_o,
  output logic               done_o,
  output logic               status_o,
  output logic [ENTRY_W-1:0] rd_data_o
);
  localparam logic [IOBA_W-1:0] PG_SIZE  = IOBA_W'(1) << PAGE_SHIFT;
  localparam logic [IOBA_W-1:0] PG_MASK  = ~(PG_SIZE - IOBA_W'(1));
  localparam int                CMP_W    = (CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1;
  localparam logic [MADDR_W-1:0] LSTRIDE = MADDR_W'(ENTRY_W / 8);

  tts_state_e          state_q, state_d;
  tts_op_e             op_q;
  logic [IOBA_W-1:0]   addr_q;
  logic [ENTRY_W-1:0]  val_q;
  logic [CNT_W-1:0]    remain_q;
  logic [MADDR_W-1:0]  lptr_q;
  logic                status_q;
  logic [ENTRY_W-1:0]  rd_q;

  logic                set_err, set_ok;
  logic                fetch_start;
  logic                in_range;
  logic [IOBA_W-1:0]   cur_iova;
  logic                entry_valid;
  logic [ENTRY_W-1:0]  list_entry;
  logic                last_page;
  logic [CMP_W-1:0]    remain_x, ne_x;

  assign remain_x  = CMP_W'(remain_q);
  assign ne_x      = CMP_W'(num_entries_i);
  assign last_page = (remain_q == CNT_W'(1));

  tts_index_calc #(.IOBA_W(IOBA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_idx (
    .addr_i     (addr_q),
    .base_i     (bus_offset_i),
    .count_i    (num_entries_i),
    .idx_o      (tbl_idx_o),
    .in_range_o (in_range),
    .iova_o     (cur_iova)
  );

  tts_list_fetch #(.ENTRY_W(ENTRY_W), .MADDR_W(MADDR_W)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (fetch_start),
    .addr_i        (lptr_q),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .entry_valid_o (entry_valid),
    .entry_o       (list_entry)
  );

  tts_notice #(.IOBA_W(IOBA_W), .ENTRY_W(ENTRY_W), .PAGE_SHIFT(PAGE_SHIFT)) u_note (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (tbl_we_o),
    .iova_i      (cur_iova),
    .entry_i     (tbl_wdata_o),
    .inv_valid_o (inv_valid_o),
    .inv_iova_o  (inv_iova_o),
    .inv_pa_o    (inv_pa_o),
    .inv_mask_o  (inv_mask_o),
    .inv_perm_o  (inv_perm_o)
  );

  always_comb begin
    state_d     = state_q;
    tbl_we_o    = 1'b0;
    tbl_re_o    = 1'b0;
    tbl_wdata_o = val_q;
    fetch_start = 1'b0;
    set_err     = 1'b0;
    set_ok      = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) state_d = S_CHECK;
      S_CHECK: begin
        unique case (op_q)
          OP_PUT: state_d = S_STEP;
          OP_FILL: begin
            if (remain_x > ne_x) begin
              set_err = 1'b1;
              state_d = S_DONE;
            end else if (remain_q == '0) begin
              set_ok  = 1'b1;
              state_d = S_DONE;
            end else begin
              state_d = S_STEP;
            end
          end
          OP_LIST: begin
            if (remain_q > CNT_W'(LIST_MAX) || remain_q == '0 ||
                lptr_q[LIST_ALIGN-1:0] != '0) begin
              set_err = 1'b1;
              state_d = S_DONE;
            end else begin
              state_d = S_FETCH;
            end
          end
          default: state_d = S_RD;
        endcase
      end
      S_STEP: begin
        if (!in_range) begin
          set_err = 1'b1;
          state_d = S_DONE;
        end else begin
          tbl_we_o = 1'b1;
          if (last_page) begin
            set_ok  = 1'b1;
            state_d = S_DONE;
          end
        end
      end
      S_FETCH: begin
        if (!in_range) begin
          set_err = 1'b1;
          state_d = S_DONE;
        end else begin
          fetch_start = 1'b1;
          state_d     = S_WAIT;
        end
      end
      S_WAIT: begin
        if (entry_valid) begin
          tbl_we_o    = 1'b1;
          tbl_wdata_o = list_entry;
          if (last_page) begin
            set_ok  = 1'b1;
            state_d = S_DONE;
          end else begin
            state_d = S_FETCH;
          end
        end
      end
      S_RD: begin
        if (!in_range) begin
          set_err = 1'b1;
          state_d = S_DONE;
        end else begin
          tbl_re_o = 1'b1;
          state_d  = S_RD_WAIT;
        end
      end
      S_RD_WAIT: begin
        set_ok  = 1'b1;
        state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_PUT;
      addr_q   <= '0;
      val_q    <= '0;
      remain_q <= '0;
      lptr_q   <= '0;
      status_q <= ST_OK;
      rd_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && cmd_valid_i) begin
        op_q     <= tts_op_e'(cmd_op_i);
        addr_q   <= cmd_ioba_i & PG_MASK;
        val_q    <= cmd_data_i;
        remain_q <= (tts_op_e'(cmd_op_i) == OP_PUT) ? CNT_W'(1) : cmd_count_i;
        lptr_q   <= cmd_data_i[MADDR_W-1:0];
      end
      if (tbl_we_o) begin
        addr_q   <= addr_q + PG_SIZE;
        remain_q <= remain_q - CNT_W'(1);
        lptr_q   <= lptr_q + LSTRIDE;
      end
      if (set_err) status_q <= ST_PARAM;
      if (set_ok)  status_q <= ST_OK;
      if (state_q == S_RD_WAIT) rd_q <= tbl_rdata_i;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign status_o  = status_q;
  assign rd_data_o = rd_q;

  AST_WRITE_IN_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> ({1'b0, tbl_idx_o} < num_entries_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tbl_we_o, tbl_re_o, done_o})); // R8
  AST_BUSY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tbl_we_o && !tbl_re_o && !mem_req_o)); // R9
  AST_LIST_NO_READ_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && set_err) |=> !mem_req_o); // R4
endmodule

// File: tb/tb_tts_seq.sv
module tb_tts_seq;
  localparam int IOBA_W = 32;
  localparam int ENTRY_W = 64;
  localparam int MADDR_W = 40;
  localparam int CNT_W = 16;
  localparam int IDX_W = 20;
  localparam logic [31:0] OFF = 32'h1000_0000;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [IOBA_W-1:0] cmd_ioba = '0;
  logic [ENTRY_W-1:0] cmd_data = '0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic busy;
  logic [IOBA_W-1:0] bus_offset = OFF;
  logic [IDX_W:0] num_entries = (IDX_W+1)'(NE);
  logic tbl_we, tbl_re;
  logic [IDX_W-1:0] tbl_idx;
  logic [ENTRY_W-1:0] tbl_wdata;
  logic [ENTRY_W-1:0] tbl_rdata = '0;
  logic mem_req;
  logic [MADDR_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [ENTRY_W-1:0] mem_rdata = '0;
  logic inv_valid;
  logic [IOBA_W-1:0] inv_iova;
  logic [ENTRY_W-1:0] inv_pa, inv_mask;
  logic [1:0] inv_perm;
  logic done, status;
  logic [ENTRY_W-1:0] rd_data;

  always #10 clk = ~clk;

  tts_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ioba_i(cmd_ioba), .cmd_data_i(cmd_data), .cmd_count_i(cmd_count), .busy_o(busy),
    .bus_offset_i(bus_offset), .num_entries_i(num_entries), .tbl_we_o(tbl_we),
    .tbl_re_o(tbl_re), .tbl_idx_o(tbl_idx), .tbl_wdata_o(tbl_wdata), .tbl_rdata_i(tbl_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .inv_valid_o(inv_valid), .inv_iova_o(inv_iova),
    .inv_pa_o(inv_pa), .inv_mask_o(inv_mask), .inv_perm_o(inv_perm), .done_o(done),
    .status_o(status), .rd_data_o(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_word(input logic [MADDR_W-1:0] a);
    return {a[31:0] ^ 32'h5A3C_0F11, a[31:0] | 32'h0000_0C02};
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction

  // external table and list memory
  logic [63:0] tbl_mem [0:63];
  logic [63:0] mdl [0:63];
  int mdly = 0;
  logic [MADDR_W-1:0] maddr_q = '0;

  always @(posedge clk) begin
    if (tbl_we) tbl_mem[tbl_idx[5:0]] <= tbl_wdata;
    if (tbl_re) tbl_rdata <= tbl_mem[tbl_idx[5:0]];
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      mdly <= 2;
      maddr_q <= mem_addr;
    end else if (mdly != 0) begin
      mdly <= mdly - 1;
      if (mdly == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem_word(maddr_q);
      end
    end
  end

  // reference model expectations
  int exp_idx_q[$];
  logic [63:0] exp_val_q[$];
  logic [MADDR_W-1:0] exp_ma_q[$];
  bit note_pend = 0;
  logic [31:0] n_iova;
  logic [63:0] n_pa;
  logic [1:0] n_perm;
  int last_we_cyc = 0;
  bit done_seen = 0;
  bit done_st;
  int done_cyc;
  logic [63:0] done_rd;

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (note_pend) begin
        chk(inv_valid && inv_iova == n_iova && inv_pa == n_pa && inv_mask == 64'hFFF
            && inv_perm == n_perm, "R6 notice", {inv_iova, inv_pa[31:0]}, {n_iova, n_pa[31:0]});
        note_pend = 0;
      end else if (inv_valid) begin
        chk(0, "R6 spurious notice", 64'(inv_iova), 64'h0);
      end
      if (tbl_we) begin
        if (exp_idx_q.size() == 0) begin
          chk(0, "R1 unexpected write", 64'(tbl_idx), 64'hFFFF_FFFF);
        end else begin
          int ei;
          logic [63:0] ev;
          ei = exp_idx_q.pop_front();
          ev = exp_val_q.pop_front();
          chk(tbl_idx == IDX_W'(ei) && tbl_wdata == ev, "R1 write index/data",
              {12'h0, tbl_idx, tbl_wdata[31:0]}, {12'h0, IDX_W'(ei), ev[31:0]});
          note_pend = 1;
          n_iova = 32'(ei) << 12;
          n_pa = ev & ~64'hFFF;
          n_perm = ev[1:0];
        end
        last_we_cyc = cyc;
      end
      if (mem_req) begin
        if (exp_ma_q.size() == 0) chk(0, "R5 unexpected list read", 64'(mem_addr), 64'h0);
        else begin
          logic [MADDR_W-1:0] em;
          em = exp_ma_q.pop_front();
          chk(mem_addr == em, "R5 list read address", 64'(mem_addr), 64'(em));
        end
      end
      if (done) begin
        done_seen = 1;
        done_st = status;
        done_cyc = cyc;
        done_rd = rd_data;
      end
    end
  end

  task automatic push_wr(input int idx, input logic [63:0] v);
    exp_idx_q.push_back(idx);
    exp_val_q.push_back(v);
    mdl[idx] = v;
  endtask

  task automatic run(input logic [1:0] op, input logic [31:0] ioba, input logic [63:0] data,
                     input int cnt, input bit poke, input string tag);
    logic [31:0] a, rb;
    int idx, nw, guard;
    bit st;
    logic [63:0] erd;
    logic [MADDR_W-1:0] ma;
    a = ioba & 32'hFFFF_F000;
    st = 0; nw = 0; erd = '0;
    case (op)
      2'd0: begin
        rb = a - OFF; idx = int'(rb >> 12);
        if (idx >= NE) st = 1; else begin push_wr(idx, data); nw++; end
      end
      2'd1: begin
        if (cnt > NE) st = 1;
        else for (int i = 0; i < cnt; i++) begin
          rb = a - OFF; idx = int'(rb >> 12);
          if (idx >= NE) begin st = 1; break; end
          push_wr(idx, data); nw++;
          a = a + 32'h1000;
        end
      end
      2'd2: begin
        if (cnt > 512 || cnt == 0 || data[11:0] != 12'h0) st = 1;
        else for (int i = 0; i < cnt; i++) begin
          rb = a - OFF; idx = int'(rb >> 12);
          if (idx >= NE) begin st = 1; break; end
          ma = data[MADDR_W-1:0] + MADDR_W'(8 * i);
          exp_ma_q.push_back(ma);
          push_wr(idx, bswap(mem_word(ma))); nw++;
          a = a + 32'h1000;
        end
      end
      default: begin
        rb = a - OFF; idx = int'(rb >> 12);
        if (idx >= NE) st = 1; else erd = mdl[idx];
      end
    endcase
    done_seen = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ioba = ioba; cmd_data = data; cmd_count = CNT_W'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, {tag, " R9 busy after accept"}, 64'(busy), 64'h1);
    if (poke) begin
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_ioba = OFF; cmd_data = 64'hDEAD_BEEF_0000_0003;
      @(negedge clk);
      cmd_valid = 1'b0;
      @(negedge clk);
    end
    guard = 0;
    while (!done_seen && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_seen, {tag, " R8 done seen"}, 64'(done_seen), 64'h1);
    chk(done_st == st, {tag, " R8 status"}, 64'(done_st), 64'(st));
    chk(exp_idx_q.size() == 0, {tag, " R2 all expected writes made"}, 64'(exp_idx_q.size()), 64'h0);
    chk(exp_ma_q.size() == 0, {tag, " R5 all list reads made"}, 64'(exp_ma_q.size()), 64'h0);
    if (nw > 0 && !st)
      chk(done_cyc == last_we_cyc + 1, {tag, " R8 done one cycle after last write"},
          64'(done_cyc), 64'(last_we_cyc + 1));
    if (op == 2'd3 && !st) chk(done_rd == erd, {tag, " R7 read data"}, done_rd, erd);
    exp_idx_q.delete(); exp_val_q.delete(); exp_ma_q.delete();
    @(negedge clk);
    chk(busy == 1'b0, {tag, " R9 idle after done"}, 64'(busy), 64'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin tbl_mem[i] = '0; mdl[i] = '0; end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && tbl_we == 0 && inv_valid == 0 && mem_req == 0,
        "R9 reset state", {busy, done, tbl_we, inv_valid, mem_req}, 64'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1: unaligned put lands on page 3
    run(2'd0, OFF + 32'h3123, 64'h0000_00AB_CDEF_1003, 0, 0, "R1");
    // R2: put at index == entry count, and below the bus offset
    run(2'd0, OFF + 32'h0001_0000, 64'h1, 0, 0, "R2");
    run(2'd0, OFF - 32'h1000, 64'h2, 0, 0, "R2");
    // R7: get within and outside the table
    run(2'd3, OFF + 32'h3FFF, 64'h0, 0, 0, "R7");
    run(2'd3, OFF + 32'h0001_4000, 64'h0, 0, 0, "R7");
    // R3 and R9: fill 5 pages with a command poked while busy
    run(2'd1, OFF + 32'h2005, 64'h0000_0012_3456_7002, 5, 1, "R3");
    run(2'd3, OFF + 32'h6000, 64'h0, 0, 0, "R3");
    run(2'd3, OFF, 64'h0, 0, 0, "R9");
    // R2: fill crossing the top of the table keeps earlier pages
    run(2'd1, OFF + 32'hD000, 64'h0000_0077_0000_0001, 5, 0, "R2");
    run(2'd3, OFF + 32'hF000, 64'h0, 0, 0, "R2");
    // R3: over-long and empty fills, then a full-table fill
    run(2'd1, OFF, 64'h5, 17, 0, "R3");
    run(2'd1, OFF, 64'h6, 0, 0, "R3");
    run(2'd1, OFF, 64'h0000_0099_0000_0003, 16, 0, "R3");
    // R5: list copy of 4 entries
    run(2'd2, OFF + 32'h8000, 64'h0002_0000, 4, 0, "R5");
    run(2'd3, OFF + 32'h9000, 64'h0, 0, 0, "R5");
    // R4: rejected list copies
    run(2'd2, OFF, 64'h0002_0008, 2, 0, "R4");
    run(2'd2, OFF, 64'h0003_0000, 513, 0, "R4");
    run(2'd2, OFF, 64'h0003_0000, 0, 0, "R4");
    run(2'd3, OFF, 64'h0, 0, 0, "R4");
    // R2: list copy crossing the top of the table
    run(2'd2, OFF + 32'hE000, 64'h0004_0000, 4, 0, "R2");
    run(2'd3, OFF + 32'hF000, 64'h0, 0, 0, "R2");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule